// File: doc/BRIEF.md
# Serial Flash Write-Enable Controller

This block sits on the slave side of a serial flash command port. It handles only the instructions that grant or withdraw write permission. While chip select is low, it collects an 8-bit opcode from the serial data input, most significant bit first, on rising edges of the serial clock. It acts on the opcode only when chip select returns high. The serial pins are brought into the block's own clock domain through a synchronizer, so the serial clock must run well below the system clock.

The block keeps two state bits. The first is a write-enable latch, which is set and cleared by its own opcodes and is presented to the downstream program and erase logic. The second is a single-shot arm for status-register writes. When a status-register write arrives while the arm is set, the block emits a one-cycle grant pulse to the status logic. Any other completed instruction that follows the arm uses it up. The block never drives the serial output.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `wel` is 0, the internal arm is clear and `sr_wr_grant` is 0.
- R2: A complete frame carrying opcode 0x06 sets `wel` to 1.
- R3: A complete frame carrying opcode 0x04 clears `wel` to 0.
- R4: Opcode bits are taken from `spi_si` on rising `spi_sck` edges while `spi_cs_n` is low, most significant bit first. The bit-reversed patterns 0x60 and 0x20 therefore act as ordinary unknown opcodes.
- R5: A command acts only after `spi_cs_n` rises. If `spi_cs_n` goes high between two `clk` edges, `wel` and `sr_wr_grant` change on the third rising `clk` edge that follows, and not earlier.
- R6: A frame that ends after any count of rising `spi_sck` edges other than exactly 8 (for example 5, 7 or 9) is ignored. `wel` and the arm keep their values.
- R7: The block behaves the same whether `spi_sck` idles low (mode 0) or high (mode 3) while `spi_cs_n` is high.
- R8: `so_oe` stays 0 at all times, so the serial output is left in high impedance.
- R9: A complete frame with opcode 0x50 sets the arm. A following complete frame with opcode 0x01 produces exactly one `sr_wr_grant` pulse, one `clk` cycle wide.
- R10: Any complete frame that follows the arm, of whatever opcode, clears the arm unless the opcode is 0x50. An opcode 0x01 frame received without the arm produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock (mode 0 or mode 3) |
| spi_si | input | 1 | Serial data input |
| so_oe | output | 1 | Serial output drive enable, always 0 |
| wel | output | 1 | Write-enable latch |
| sr_wr_grant | output | 1 | One-cycle grant for a status-register write |

## Verification
Every result of this block appears three `clk` rising edges after `spi_cs_n` goes high: two edges pass through the synchronizer and the third loads the latch or the grant register. The bench checks the latency directly. It confirms that `wel` still holds its old value at the second falling edge after the rise and holds the new value at the third. For all other frames, the scoreboard monitor waits six falling edges after the frame closes before it compares `wel`, the running count of grant pulses and `so_oe`. The driver holds the bus idle for ten cycles, so no frame overlaps a pending comparison.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  localparam int OP_W = 8;

  typedef logic [OP_W-1:0] opcode_t;

  localparam opcode_t OPC_WEL_SET  = 8'h06;
  localparam opcode_t OPC_WEL_CLR  = 8'h04;
  localparam opcode_t OPC_SR_ARM   = 8'h50;
  localparam opcode_t OPC_SR_WRITE = 8'h01;

  typedef enum logic [2:0] {
    K_WEL_SET,
    K_WEL_CLR,
    K_SR_ARM,
    K_SR_WRITE,
    K_OTHER
  } cmd_kind_e;

  function automatic cmd_kind_e classify(opcode_t op);
    case (op)
      OPC_WEL_SET:  return K_WEL_SET;
      OPC_WEL_CLR:  return K_WEL_CLR;
      OPC_SR_ARM:   return K_SR_ARM;
      OPC_SR_WRITE: return K_SR_WRITE;
      default:      return K_OTHER;
    endcase
  endfunction

  // MSB-first accumulation: earlier bits move toward the top.
  function automatic opcode_t shift_in(opcode_t cur, logic bit_in);
    return {cur[OP_W-2:0], bit_in};
  endfunction

endpackage

// File: rtl/flash_wp_sync.sv
module flash_wp_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/flash_wp_frame.sv
module flash_wp_frame
  import flash_wp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n_s,
  input  logic    sck_s,
  input  logic    si_s,
  output logic    exec_valid,
  output logic    frame_abort,
  output opcode_t exec_op
);

  localparam int CNT_W = $clog2(OP_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(OP_W + 1);

  logic             cs_prev;
  logic             sck_prev;
  logic [CNT_W-1:0] bit_cnt;
  opcode_t          shreg;

  logic sck_rise;
  logic cs_rise;

  assign sck_rise = sck_s & ~sck_prev;
  assign cs_rise  = cs_n_s & ~cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_n_s;
      sck_prev <= sck_s;
    end
  end

  // Counter saturates one past a full byte so long frames never alias to 8.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (cs_n_s) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      shreg <= shift_in(shreg, si_s);
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign exec_valid  = cs_rise && (bit_cnt == CNT_FULL);
  assign frame_abort = cs_rise && (bit_cnt != CNT_FULL);
  assign exec_op     = shreg;

endmodule

// File: rtl/flash_wp_latch.sv
module flash_wp_latch
  import flash_wp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    exec_valid,
  input  opcode_t exec_op,
  output logic    wel,
  output logic    arm,
  output logic    grant
);

  cmd_kind_e kind;

  always_comb kind = classify(exec_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      arm   <= 1'b0;
      grant <= 1'b0;
    end else begin
      grant <= 1'b0;
      if (exec_valid) begin
        case (kind)
          K_WEL_SET: wel <= 1'b1;
          K_WEL_CLR: wel <= 1'b0;
          default:   wel <= wel;
        endcase
        grant <= (kind == K_SR_WRITE) && arm;
        arm   <= (kind == K_SR_ARM);
      end
    end
  end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_si,
  output logic so_oe,
  output logic wel,
  output logic sr_wr_grant
);

  logic [2:0] pins_s;
  logic       exec_valid;
  logic       frame_abort;
  opcode_t    exec_op;
  logic       arm_q;

  flash_wp_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_cs_n, spi_sck, spi_si}),
    .q    (pins_s)
  );

  flash_wp_frame frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (pins_s[2]),
    .sck_s      (pins_s[1]),
    .si_s       (pins_s[0]),
    .exec_valid (exec_valid),
    .frame_abort(frame_abort),
    .exec_op    (exec_op)
  );

  flash_wp_latch latch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_valid(exec_valid),
    .exec_op   (exec_op),
    .wel       (wel),
    .arm       (arm_q),
    .grant     (sr_wr_grant)
  );

  assign so_oe = 1'b0;

endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk
  import flash_wp_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    wel,
  input logic    grant,
  input logic    arm,
  input logic    exec_valid,
  input logic    frame_abort,
  input opcode_t exec_op
);

  // R2
  wel_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(exec_valid && exec_op == OPC_WEL_SET));

  // R3
  wel_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> $past(exec_valid && exec_op == OPC_WEL_CLR));

  // R6
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> ($stable(wel) && $stable(arm)));

  // R9
  grant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(exec_valid && exec_op == OPC_SR_WRITE && arm));

  // R9
  grant_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  // R9
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_op == OPC_SR_ARM) |=> arm);

  // R10
  arm_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_op != OPC_SR_ARM) |=> !arm);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!wel && !arm && !grant));

endmodule

bind flash_wp_ctrl flash_wp_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wel        (wel),
  .grant      (sr_wr_grant),
  .arm        (arm_q),
  .exec_valid (exec_valid),
  .frame_abort(frame_abort),
  .exec_op    (exec_op)
);

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_si = 1'b0;
  logic so_oe;
  logic wel;
  logic sr_wr_grant;

  always #2 clk = ~clk;

  flash_wp_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .spi_si     (spi_si),
    .so_oe      (so_oe),
    .wel        (wel),
    .sr_wr_grant(sr_wr_grant)
  );

  typedef struct {
    string tag;
    bit    wel_e;
    int    grants_e;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   gcnt     = 0;
  bit   wel_m    = 1'b0;
  bit   arm_m    = 1'b0;
  int   gexp     = 0;
  bit   done     = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (sr_wr_grant) gcnt++;

  // Reference model of the command effects, written from the requirements.
  task automatic model(input logic [15:0] val, input int n);
    logic [7:0] op;
    if (n == 8) begin
      op = val[7:0];
      if (op == 8'h06) wel_m = 1'b1;
      if (op == 8'h04) wel_m = 1'b0;
      if (op == 8'h01 && arm_m) gexp++;
      arm_m = (op == 8'h50);
    end
  endtask

  task automatic xfer(input logic [15:0] val, input int n, input bit m3,
                      input string tag, input bit lat);
    exp_t it;
    bit   old_wel;
    old_wel = wel_m;
    @(negedge clk);
    spi_sck = m3;
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (m3) spi_sck = 1'b0;
      spi_si = val[n-1-i];
      repeat (4) @(negedge clk);
      spi_sck = 1'b1;
      repeat (4) @(negedge clk);
      if (!m3) spi_sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(wel == old_wel, "R5", "wel before cs rise", wel, old_wel);
    spi_cs_n = 1'b1;
    model(val, n);
    if (lat) begin
      repeat (2) @(negedge clk);
      check(wel == old_wel, "R5", "wel two edges after cs rise", wel, old_wel);
      @(negedge clk);
      check(wel == wel_m, "R5", "wel three edges after cs rise", wel, wel_m);
    end
    it.tag = tag;
    it.wel_e = wel_m;
    it.grants_e = gexp;
    sb.push_back(it);
    repeat (10) @(negedge clk);
  endtask

  // Scoreboard monitor
  initial begin
    exp_t it;
    forever begin
      wait (sb.size() > 0);
      repeat (6) @(negedge clk);
      it = sb.pop_front();
      check(wel == it.wel_e, it.tag, "wel", wel, it.wel_e);
      check(gcnt == it.grants_e, it.tag, "grant pulses", gcnt, it.grants_e);
      check(so_oe == 1'b0, "R8", "so_oe", so_oe, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wel == 1'b0, "R1", "wel in reset", wel, 0);
    check(sr_wr_grant == 1'b0, "R1", "grant in reset", sr_wr_grant, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(wel == 1'b0, "R1", "wel after reset", wel, 0);
    check(so_oe == 1'b0, "R8", "so_oe after reset", so_oe, 0);

    xfer(16'h06, 8, 1'b0, "R2", 1'b1);
    xfer(16'h04, 8, 1'b0, "R3", 1'b1);
    xfer(16'h06, 8, 1'b1, "R7", 1'b1);
    xfer(16'h02, 7, 1'b0, "R6", 1'b0);
    xfer(16'h008, 9, 1'b0, "R6", 1'b0);
    xfer(16'h20, 8, 1'b0, "R4", 1'b0);
    xfer(16'h04, 8, 1'b1, "R7", 1'b0);
    xfer(16'h60, 8, 1'b0, "R4", 1'b0);
    xfer(16'h50, 8, 1'b0, "R9", 1'b0);
    xfer(16'h01, 8, 1'b0, "R9", 1'b0);
    xfer(16'h01, 8, 1'b0, "R10", 1'b0);
    xfer(16'h50, 8, 1'b1, "R9", 1'b0);
    xfer(16'h06, 8, 1'b0, "R10", 1'b0);
    xfer(16'h01, 8, 1'b0, "R10", 1'b0);
    xfer(16'h50, 8, 1'b0, "R9", 1'b0);
    xfer(16'h0A, 5, 1'b1, "R6", 1'b0);
    xfer(16'h01, 8, 1'b1, "R9", 1'b0);
    xfer(16'h50, 8, 1'b0, "R10", 1'b0);
    xfer(16'hAB, 8, 1'b0, "R10", 1'b0);
    xfer(16'h01, 8, 1'b0, "R10", 1'b0);

    wait (sb.size() == 0);
    repeat (8) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule